// File: doc/BRIEF.md
# System Bus Address Decoder

This block sits between a 24-bit processor bus and the rest of a console system. It reads the current address, split into an 8-bit bank and a 16-bit offset, together with active-low read and write strobes, and decides which resource answers. The resource can be cartridge ROM, internal work RAM, the 8-bit peripheral bus, or the processor's own register file. If none of them answers, the access goes to open bus.

The cartridge ROM select follows the address bits alone, so it changes as soon as the address changes. Every other select waits for a strobe. Banks $7E and $7F belong entirely to work RAM. The low 8 KiB of each system bank ($00-$3F and $80-$BF) mirrors the start of bank $7E. A 256-byte window in the system banks leads to the peripheral bus, which carries an 8-bit address taken from the offset's low byte. The full address and both strobes are also passed to the cartridge edge on every cycle, mapped or not. The block is purely combinational.

Top module: `sysbus_decode`

## Requirements
- R1: `rom_sel_n` is 0 exactly when (bank bit 6 = 1 or offset bit 15 = 1) and bank is neither $7E nor $7F; it does not depend on `cpu_rd_n`/`cpu_wr_n`.
- R2: For bank $7E or $7F with either strobe low, `wram_sel_n` = 0 and `wram_addr` = {bank bit 0, offset}.
- R3: For a bank with bit 6 = 0 and offset $0000-$1FFF with either strobe low, `wram_sel_n` = 0 and `wram_addr` = {4'b0000, offset[12:0]}.
- R4: While both `cpu_rd_n` and `cpu_wr_n` are 1, `wram_sel_n`, `bb_rd_n` and `bb_wr_n` are 1, and `reg_hit` and `open_bus` are 0.
- R5: For a bank with bit 6 = 0 and offset $2100-$21FF, `bb_rd_n` equals `cpu_rd_n` and `bb_wr_n` equals `cpu_wr_n`. Outside that window both stay 1. `bb_addr` always equals offset[7:0].
- R6: `reg_hit` = 1 exactly when bank bit 6 = 0, offset is $4000-$43FF and either strobe is low.
- R7: `open_bus` = 1 exactly when either strobe is low and none of these holds: `rom_sel_n` = 0, `wram_sel_n` = 0, `bb_rd_n` = 0, `bb_wr_n` = 0, `reg_hit` = 1.
- R8: At most one of the following is active at any time: ROM select, work-RAM select, a peripheral strobe (either one), register hit.
- R9: `bus_addr` = {bank, offset}, `bus_rd_n` = `cpu_rd_n` and `bus_wr_n` = `cpu_wr_n` on every access, including unmapped ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_bank | input | 8 | Address bank (A23..A16) |
| cpu_ofs | input | 16 | Address offset (A15..A0) |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| rom_sel_n | output | 1 | Cartridge ROM select, active low, address-only |
| wram_sel_n | output | 1 | Work-RAM select, active low |
| wram_addr | output | 17 | Work-RAM word address |
| bb_rd_n | output | 1 | Peripheral bus read strobe, active low |
| bb_wr_n | output | 1 | Peripheral bus write strobe, active low |
| bb_addr | output | 8 | Peripheral bus address |
| reg_hit | output | 1 | Internal register file claims the access |
| open_bus | output | 1 | Access with no responder |
| bus_addr | output | 24 | Address passed to the cartridge edge |
| bus_rd_n | output | 1 | Read strobe passed to the cartridge edge |
| bus_wr_n | output | 1 | Write strobe passed to the cartridge edge |

## Verification
The assertions check the outputs only after the combinational logic has settled for a fully known address and strobe pair. They also allow both strobes to be low at once. In that case the peripheral window drives both of its strobes, and this still counts as one responder. The stimulus changes inputs only on the falling clock edge and holds them for a full cycle. It sweeps every bank against the offsets at each region boundary under all four strobe combinations, then adds seeded random addresses.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
    localparam int BANK_W  = 8;
    localparam int OFS_W   = 16;
    localparam int PA_W    = 8;
    localparam int ADDR_W  = BANK_W + OFS_W;
    localparam int WRAM_AW = OFS_W + 1;
    localparam int LORAM_W = 13;
    localparam int PAD_W   = WRAM_AW - LORAM_W;

    // upper seven bank bits shared by the two work-RAM banks
    localparam logic [BANK_W-2:0] WRAM_BANK_HI = 7'h3F;
    localparam logic [OFS_W-1:0]  LORAM_TOP    = 16'h1FFF;
    localparam logic [OFS_W-1:0]  BB_LO        = 16'h2100;
    localparam logic [OFS_W-1:0]  BB_HI        = 16'h21FF;
    localparam logic [OFS_W-1:0]  REG_LO       = 16'h4000;
    localparam logic [OFS_W-1:0]  REG_HI       = 16'h43FF;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFS_W-1:0]  ofs;
    } cpu_addr_t;

    // strobes held active-high inside the decoder
    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    function automatic logic is_sys_bank(input logic [BANK_W-1:0] b);
        return ~b[6];
    endfunction

    function automatic logic is_wram_bank(input logic [BANK_W-1:0] b);
        return b[BANK_W-1:1] == WRAM_BANK_HI;
    endfunction

    function automatic logic in_window(input logic [OFS_W-1:0] o,
                                       input logic [OFS_W-1:0] lo,
                                       input logic [OFS_W-1:0] hi);
        return (o >= lo) && (o <= hi);
    endfunction
endpackage

// File: rtl/sbd_rom_sel.sv
module sbd_rom_sel
    import sysbus_pkg::*;
(
    input  cpu_addr_t a,
    output logic      sel
);
    always_comb begin
        sel = (a.bank[6] | a.ofs[OFS_W-1]) & ~is_wram_bank(a.bank);
    end
endmodule

// File: rtl/sbd_wram.sv
module sbd_wram
    import sysbus_pkg::*;
#(
    parameter bit GATE_ON_STROBE = 1'b1
) (
    input  cpu_addr_t          a,
    input  strobe_t            s,
    output logic               sel,
    output logic [WRAM_AW-1:0] addr
);
    logic hit_full, hit_mirror, hit;

    always_comb begin
        hit_full   = is_wram_bank(a.bank);
        hit_mirror = is_sys_bank(a.bank) && (a.ofs <= LORAM_TOP);
        hit        = hit_full | hit_mirror;
        if (hit_mirror)
            addr = {{PAD_W{1'b0}}, a.ofs[LORAM_W-1:0]};
        else
            addr = {a.bank[0], a.ofs};
    end

    generate
        if (GATE_ON_STROBE) begin : g_gated
            assign sel = hit & (s.rd | s.wr);
        end else begin : g_ungated
            assign sel = hit;
        end
    endgenerate
endmodule

// File: rtl/sbd_bbus.sv
module sbd_bbus
    import sysbus_pkg::*;
(
    input  cpu_addr_t       a,
    input  strobe_t         s,
    output logic            rd,
    output logic            wr,
    output logic [PA_W-1:0] pa
);
    logic win;

    always_comb begin
        win = is_sys_bank(a.bank) && in_window(a.ofs, BB_LO, BB_HI);
        rd  = win & s.rd;
        wr  = win & s.wr;
        pa  = a.ofs[PA_W-1:0];
    end
endmodule

// File: rtl/sbd_regs.sv
module sbd_regs
    import sysbus_pkg::*;
(
    input  cpu_addr_t a,
    input  strobe_t   s,
    output logic      hit
);
    always_comb begin
        hit = is_sys_bank(a.bank) && in_window(a.ofs, REG_LO, REG_HI)
              && (s.rd | s.wr);
    end
endmodule

// File: rtl/sysbus_decode.sv
module sysbus_decode
    import sysbus_pkg::*;
(
    input  logic [7:0]  cpu_bank,
    input  logic [15:0] cpu_ofs,
    input  logic        cpu_rd_n,
    input  logic        cpu_wr_n,
    output logic        rom_sel_n,
    output logic        wram_sel_n,
    output logic [16:0] wram_addr,
    output logic        bb_rd_n,
    output logic        bb_wr_n,
    output logic [7:0]  bb_addr,
    output logic        reg_hit,
    output logic        open_bus,
    output logic [23:0] bus_addr,
    output logic        bus_rd_n,
    output logic        bus_wr_n
);
    cpu_addr_t a;
    strobe_t   s;
    logic      rom_sel, wram_sel, bb_rd, bb_wr, reg_sel, access;

    assign a.bank = cpu_bank;
    assign a.ofs  = cpu_ofs;
    assign s.rd   = ~cpu_rd_n;
    assign s.wr   = ~cpu_wr_n;
    assign access = s.rd | s.wr;

    sbd_rom_sel u_rom (.a(a), .sel(rom_sel));

    sbd_wram #(.GATE_ON_STROBE(1'b1)) u_wram (
        .a(a), .s(s), .sel(wram_sel), .addr(wram_addr)
    );

    sbd_bbus u_bb (.a(a), .s(s), .rd(bb_rd), .wr(bb_wr), .pa(bb_addr));

    sbd_regs u_reg (.a(a), .s(s), .hit(reg_sel));

    always_comb begin
        rom_sel_n  = ~rom_sel;
        wram_sel_n = ~wram_sel;
        bb_rd_n    = ~bb_rd;
        bb_wr_n    = ~bb_wr;
        reg_hit    = reg_sel;
        open_bus   = access & ~(rom_sel | wram_sel | bb_rd | bb_wr | reg_sel);
        bus_addr   = {cpu_bank, cpu_ofs};
        bus_rd_n   = cpu_rd_n;
        bus_wr_n   = cpu_wr_n;
    end

    // checks across the separately built select paths
    always_comb begin
        a_r8_one_responder: assert ($countones({~rom_sel_n, ~wram_sel_n,
                                     ~(bb_rd_n & bb_wr_n), reg_hit}) <= 1)
            else $error("R8: more than one responder");
        if (cpu_rd_n && cpu_wr_n) begin
            a_r4_idle_quiet: assert (wram_sel_n && bb_rd_n && bb_wr_n
                                     && !reg_hit && !open_bus)
                else $error("R4: select active without strobe");
        end
        if (open_bus) begin
            a_r7_open_bus_alone: assert (rom_sel_n && wram_sel_n && bb_rd_n
                                         && bb_wr_n && !reg_hit)
                else $error("R7: open bus with a responder");
        end
        if (!wram_sel_n && cpu_bank[7:1] == 7'h3F) begin
            a_r2_wram_bank_addr: assert (wram_addr == {cpu_bank[0], cpu_ofs})
                else $error("R2: work-RAM address wrong");
        end
        a_r5_pa_from_bus: assert (bb_addr == bus_addr[7:0])
            else $error("R5: peripheral address mismatch");
        if (!rom_sel_n) begin
            a_r1_rom_not_wram_bank: assert (bus_addr[23:17] != 7'h3F)
                else $error("R1: ROM select in work-RAM bank");
        end
    end
endmodule

// File: tb/sysbus_decode_test.sv
module sysbus_decode_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cpu_bank = '0;
    logic [15:0] cpu_ofs  = '0;
    logic        cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
    logic        rom_sel_n, wram_sel_n, bb_rd_n, bb_wr_n, reg_hit, open_bus;
    logic        bus_rd_n, bus_wr_n;
    logic [16:0] wram_addr;
    logic [7:0]  bb_addr;
    logic [23:0] bus_addr;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sysbus_decode uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s bank=%02h ofs=%04h rd_n=%0b wr_n=%0b act=%0h exp=%0h",
                     req, cpu_bank, cpu_ofs, cpu_rd_n, cpu_wr_n, act, exp);
        end
    endtask

    function automatic bit f_sys(input logic [7:0] b); return !b[6]; endfunction
    function automatic bit f_wbank(input logic [7:0] b); return b[7:1] == 7'h3F; endfunction

    task automatic apply(input logic [7:0] b, input logic [15:0] o, input logic rn, input logic wn);
        bit acc, e_rom, e_wr, e_bbw, e_reg, e_ob, lo;
        logic [16:0] e_wa;
        @(negedge clk);
        cpu_bank = b; cpu_ofs = o; cpu_rd_n = rn; cpu_wr_n = wn;
        #1.5;
        acc   = !rn || !wn;
        e_rom = (b[6] || o[15]) && !f_wbank(b);
        lo    = f_sys(b) && o <= 16'h1FFF;
        e_wr  = acc && (f_wbank(b) || lo);
        e_wa  = lo ? {4'b0, o[12:0]} : {b[0], o};
        e_bbw = f_sys(b) && o >= 16'h2100 && o <= 16'h21FF;
        e_reg = acc && f_sys(b) && o >= 16'h4000 && o <= 16'h43FF;
        e_ob  = acc && !(e_rom || e_wr || e_bbw || e_reg);
        chk("R1", rom_sel_n, !e_rom);
        if (f_wbank(b)) chk("R2", {wram_sel_n, wram_addr}, {!e_wr, e_wa});
        else if (lo)    chk("R3", {wram_sel_n, wram_addr}, {!e_wr, e_wa});
        else            chk("R3", wram_sel_n, !e_wr);
        if (!acc) chk("R4", {wram_sel_n, bb_rd_n, bb_wr_n, reg_hit, open_bus}, 5'b11100);
        chk("R5", {bb_rd_n, bb_wr_n, bb_addr},
            {e_bbw ? rn : 1'b1, e_bbw ? wn : 1'b1, o[7:0]});
        chk("R6", reg_hit, e_reg);
        chk("R7", open_bus, e_ob);
        chk("R8", ($countones({!rom_sel_n, !wram_sel_n, !(bb_rd_n && bb_wr_n), reg_hit}) <= 1), 1);
        chk("R9", {bus_addr, bus_rd_n, bus_wr_n}, {b, o, rn, wn});
    endtask

    initial begin
        logic [15:0] edges [15];
        int unsigned seed;
        edges = '{16'h0000, 16'h1FFF, 16'h2000, 16'h20FF, 16'h2100, 16'h21FF,
                  16'h2200, 16'h3FFF, 16'h4000, 16'h43FF, 16'h4400, 16'h7FFF,
                  16'h8000, 16'hFFFF, 16'h2184};
        seed = 32'h5EED;
        void'($urandom(seed));
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // reset state: idle bus, address zero
        #1;
        chk("R4", {wram_sel_n, bb_rd_n, bb_wr_n, reg_hit, open_bus}, 5'b11100);
        for (int bk = 0; bk < 256; bk++)
            for (int e = 0; e < 15; e++)
                for (int st = 0; st < 4; st++)
                    apply(8'(bk), edges[e], st[0], st[1]);
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r = $urandom;
            apply(r[7:0], r[23:8], r[24], r[25]);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule